// File: doc/BRIEF.md
# Keyed-Feed Watchdog Timer

This block is a watchdog counter that advances on a tick input coming from an independent slow oscillator. The tick arrives as a one-cycle enable in the system clock domain. Software talks to the block through a small write port that selects one of two registers: a feed register and a control register. The control register holds a 3-bit timeout selector and an interrupt-clear bit.

A static configuration input chooses between two modes. In watchdog mode the counter must be fed with a two-byte key before it reaches its timeout, or the block emits a chip-reset pulse. The timeout may be set once after reset, and nothing in software can stop the counter. In interval-timer mode the same counter reloads itself on every expiry and raises an interrupt flag, which stays set until software clears it.

Top module: `wdt_keyed_feed`

## Requirements
- R1: The timeout is BASE_TICKS << sel ticks, where sel is control register bits [2:0]. It is counted from the end of reset, from a valid feed, or from the previous expiry. sel resets to 7.
- R2: A feed-register write (wrSel=0) of 8'h1E followed later by a feed-register write of 8'hE1 is a valid feed, and it restarts the count from zero. Control-register writes in between do not break the sequence.
- R3: After 8'h1E, a further 8'h1E keeps the sequence armed. Any other value disarms it. An 8'hE1 that is not armed does nothing, and a broken sequence leaves the expiry at its original tick.
- R4: In watchdog mode (wdEnable=1), an expiry drives wdReset high for exactly PULSE_CYCLES clock cycles. The pulse starts at the edge that takes the expiring tick. irq stays 0 in this mode.
- R5: In watchdog mode, only the first control-register write (wrSel=1) after reset takes effect. No written value stops the counter.
- R6: While rstN is low, the counter is held at zero and ticks are ignored. wdReset and irq are 0.
- R7: In interval mode (wdEnable=0), an expiry sets irq and reloads the counter. wdReset stays 0.
- R8: irq stays set until a control-register write with bit 3 set. In interval mode, every control-register write updates sel.
- R9: A valid feed that arrives in the same cycle as the tick that would expire the counter wins. No expiry occurs, and the count restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset from other chip reset sources |
| wdEnable | input | 1 | Configuration: 1 selects watchdog mode, 0 selects interval-timer mode |
| tickEn | input | 1 | One-cycle tick from the independent oscillator |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 1 | Write target: 0 is the feed register, 1 is the control register |
| wrData | input | 8 | Write data |
| wdReset | output | 1 | Chip-reset pulse on watchdog expiry |
| irq | output | 1 | Interval-timer interrupt flag |

## Verification
The bench builds the block with BASE_TICKS=4 and PULSE_CYCLES=5, so the longest timeout is 512 ticks. With these values, every one of the eight timeout settings can be swept to its exact expiry tick in both modes, with the expected count computed as 4 << sel. The short base also makes it practical to check key-sequence orderings, the same-cycle feed-versus-expiry race and the width of the reset pulse within a few thousand cycles.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam logic [7:0] KEY_ARM  = 8'h1E;
  localparam logic [7:0] KEY_FIRE = 8'hE1;
  localparam int SEL_W   = 3;
  localparam int CLR_BIT = 3;
  localparam logic [SEL_W-1:0] SEL_RESET = '1;

  typedef struct packed {
    logic restart;
    logic tick;
  } dpStrobe_t;
endpackage

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
#(
  parameter int BASE_TICKS = 1000,
  parameter int CNT_W      = 18
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic [SEL_W-1:0] sel,
  output logic             hit
);
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] limitM1;

  always_comb begin
    limitM1 = (CNT_W'(BASE_TICKS) << sel) - CNT_W'(1);
    hit     = strobe.tick && !strobe.restart && (count >= limitM1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (strobe.restart || hit) begin
      count <= '0;
    end else if (strobe.tick) begin
      count <= count + CNT_W'(1);
    end
  end

  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.tick && !strobe.restart) |=> $stable(count));
endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
#(
  parameter int PULSE_CYCLES = 125,
  localparam int PW = $clog2(PULSE_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wdEnable,
  input  logic             tickEn,
  input  logic             wrEn,
  input  logic             wrSel,
  input  logic [7:0]       wrData,
  input  logic             hit,
  output dpStrobe_t        strobe,
  output logic [SEL_W-1:0] sel,
  output logic             wdReset,
  output logic             irq
);
  logic          armed;
  logic          locked;
  logic [PW-1:0] pulseCnt;
  logic          feedWr, ctrlWr, validFeed, ctrlAccept;

  always_comb begin
    feedWr         = wrEn && !wrSel;
    ctrlWr         = wrEn && wrSel;
    validFeed      = feedWr && armed && (wrData == KEY_FIRE);
    ctrlAccept     = ctrlWr && (!wdEnable || !locked);
    strobe.restart = validFeed;
    strobe.tick    = tickEn;
    wdReset        = (pulseCnt != '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed    <= 1'b0;
      locked   <= 1'b0;
      sel      <= SEL_RESET;
      irq      <= 1'b0;
      pulseCnt <= '0;
    end else begin
      if (feedWr) armed <= (wrData == KEY_ARM);
      if (ctrlWr && wdEnable) locked <= 1'b1;
      if (ctrlAccept) sel <= wrData[SEL_W-1:0];
      if (hit && !wdEnable) irq <= 1'b1;
      else if (ctrlAccept && wrData[CLR_BIT]) irq <= 1'b0;
      if (hit && wdEnable) pulseCnt <= PW'(PULSE_CYCLES);
      else if (pulseCnt != '0) pulseCnt <= pulseCnt - PW'(1);
    end
  end

  // R5
  sel_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wdEnable && locked) |=> $stable(sel));
  // R7
  timer_no_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wdEnable |-> !wdReset);
  // R4
  wd_no_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    wdEnable |-> !irq);
  // R4
  pulse_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wdReset) |-> $past(hit));
endmodule

// File: rtl/wdt_keyed_feed.sv
module wdt_keyed_feed
  import wdt_pkg::*;
#(
  parameter int BASE_TICKS   = 1000,
  parameter int PULSE_CYCLES = 125,
  localparam int CNT_W = $clog2(BASE_TICKS * 128) + 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wdEnable,
  input  logic       tickEn,
  input  logic       wrEn,
  input  logic       wrSel,
  input  logic [7:0] wrData,
  output logic       wdReset,
  output logic       irq
);
  dpStrobe_t        strobe;
  logic [SEL_W-1:0] sel;
  logic             hit;

  wdt_ctrl #(.PULSE_CYCLES(PULSE_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .wdEnable(wdEnable), .tickEn(tickEn),
    .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData), .hit(hit),
    .strobe(strobe), .sel(sel), .wdReset(wdReset), .irq(irq)
  );

  wdt_datapath #(.BASE_TICKS(BASE_TICKS), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .sel(sel), .hit(hit)
  );
endmodule

// File: tb/wdt_keyed_feed_bench.sv
module wdt_keyed_feed_bench;
  localparam int BASE = 4;
  localparam int PULSE = 5;

  logic clk = 1'b0, rstN = 1'b0, wdEnable = 1'b1, tickEn = 1'b0;
  logic wrEn = 1'b0, wrSel = 1'b0;
  logic [7:0] wrData = '0;
  logic wdReset, irq;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  wdt_keyed_feed #(.BASE_TICKS(BASE), .PULSE_CYCLES(PULSE)) u_wdt_keyed_feed (
    .clk(clk), .rstN(rstN), .wdEnable(wdEnable), .tickEn(tickEn),
    .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData), .wdReset(wdReset), .irq(irq)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic cyc(input logic t, input logic w, input logic s, input logic [7:0] d);
    @(negedge clk);
    tickEn = t; wrEn = w; wrSel = s; wrData = d;
    @(negedge clk);
    tickEn = 1'b0; wrEn = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 1'b0, 8'h00);
  endtask

  task automatic feedWr(input logic [7:0] d);
    cyc(1'b0, 1'b1, 1'b0, d);
  endtask

  task automatic ctrlWr(input logic [7:0] d);
    cyc(1'b0, 1'b1, 1'b1, d);
  endtask

  task automatic doReset(input logic mode);
    @(negedge clk);
    rstN = 1'b0; wdEnable = mode;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  // Expects expiry on the next tick and checks the width of the pulse.
  task automatic expectPulse(input string req);
    ticks(1);
    chk(req, wdReset, 1'b1);
    chk("R4 irq", irq, 1'b0);
    repeat (PULSE - 1) @(negedge clk);
    chk("R4 last pulse cycle", wdReset, 1'b1);
    @(negedge clk);
    chk("R4 pulse end", wdReset, 1'b0);
  endtask

  initial begin
    #(8 * 200000);
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    doReset(1'b1);
    chk("R6 reset wdReset", wdReset, 1'b0);
    chk("R6 reset irq", irq, 1'b0);

    // R1 default sel 7, watchdog mode
    ticks((BASE << 7) - 1);
    chk("R1 default no expiry", wdReset, 1'b0);
    expectPulse("R1 default expiry");

    // R1 R4 sweep of all settings, including reload after expiry
    for (int s = 0; s < 8; s++) begin
      doReset(1'b1);
      ctrlWr(8'(s));
      ticks((BASE << s) - 1);
      chk("R1 before expiry", wdReset, 1'b0);
      expectPulse("R1 expiry");
      ticks((BASE << s) - 1);
      chk("R1 after reload", wdReset, 1'b0);
      expectPulse("R1 second expiry");
    end

    // R5 first write wins, second ignored
    doReset(1'b1);
    ctrlWr(8'hF8);
    ctrlWr(8'h07);
    ticks(BASE - 1);
    chk("R5 locked sel", wdReset, 1'b0);
    expectPulse("R5 locked sel expiry");

    // R2 valid feed with a control write in between
    doReset(1'b1);
    ctrlWr(8'h01);
    ticks(6);
    feedWr(8'h1E);
    ctrlWr(8'h00);
    feedWr(8'hE1);
    ticks(6);
    chk("R2 feed restarted count", wdReset, 1'b0);
    ticks(1);
    chk("R2 feed restarted count", wdReset, 1'b0);
    expectPulse("R2 expiry after feed");

    // R3 broken sequence keeps original schedule
    doReset(1'b1);
    ctrlWr(8'h01);
    ticks(3);
    feedWr(8'h1E); feedWr(8'h55); feedWr(8'hE1);
    feedWr(8'hE1);
    ticks(4);
    chk("R3 broken seq", wdReset, 1'b0);
    expectPulse("R3 broken seq original expiry");

    // R3 repeated arm key keeps sequence armed
    doReset(1'b1);
    ctrlWr(8'h01);
    ticks(6);
    feedWr(8'h1E); feedWr(8'h1E); feedWr(8'hE1);
    ticks(7);
    chk("R3 double arm feeds", wdReset, 1'b0);
    expectPulse("R3 double arm expiry");

    // R9 feed in same cycle as expiring tick
    doReset(1'b1);
    ctrlWr(8'h01);
    ticks(7);
    feedWr(8'h1E);
    cyc(1'b1, 1'b1, 1'b0, 8'hE1);
    chk("R9 feed wins", wdReset, 1'b0);
    ticks(7);
    chk("R9 count from zero", wdReset, 1'b0);
    expectPulse("R9 expiry after race");

    // R6 ticks during reset are ignored
    @(negedge clk);
    rstN = 1'b0;
    ticks(10);
    chk("R6 held wdReset", wdReset, 1'b0);
    chk("R6 held irq", irq, 1'b0);
    rstN = 1'b1;
    ctrlWr(8'h00);
    ticks(BASE - 1);
    chk("R6 count from release", wdReset, 1'b0);
    expectPulse("R6 expiry after release");

    // R7 R8 interval mode sweep
    for (int s = 0; s < 8; s++) begin
      doReset(1'b0);
      ctrlWr(8'h05);
      ctrlWr(8'(s));
      ticks((BASE << s) - 1);
      chk("R7 before irq", irq, 1'b0);
      ticks(1);
      chk("R7 irq set", irq, 1'b1);
      chk("R7 no reset", wdReset, 1'b0);
      ticks(1);
      chk("R8 irq held", irq, 1'b1);
      ctrlWr(8'(s) | 8'h08);
      chk("R8 irq cleared", irq, 1'b0);
      ticks((BASE << s) - 2);
      chk("R7 reload before", irq, 1'b0);
      ticks(1);
      chk("R7 reload irq", irq, 1'b1);
    end

    // R8 control write without clear bit leaves irq set
    ctrlWr(8'h07);
    chk("R8 no clear bit", irq, 1'b1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule